// File: doc/BRIEF.md
# Runtime Coefficient Staging Buffer with Batch Commit

This block lets a host replace filter coefficients while audio processing keeps running. The host clears a word counter, latches a target start address, and then streams up to 32 data words into a local staging buffer. Each word arrives as a series of narrow beats on a valid/data port, lowest beat first. Nothing reaches the coefficient memory while words are being loaded.

When the batch is complete, the host pulses a request. The request bit reads as 1 from that point on. The block waits for the next sample-boundary strobe and then copies the whole batch into the target memory, one word per clock. This keeps a half-updated coefficient set from ever being used across a sample. At the end of the copy the request bit drops, a completion flag is raised, and a running 8-bit checksum holds the byte sum of every word that was copied.

There is no mute and no stall of the processing side. The only effect on the memory is a short run of consecutive writes that starts right after a sample boundary.

Top module: `rtcoef_stager`

## Requirements
- R1: After reset `word_count`, `req_bit`, `irq_flag`, `checksum` and `mem_we` are 0. A `cnt_clr` pulse sets `word_count` to 0. Each completed word taken into the buffer raises `word_count` by one.
- R2: The buffer holds at most DEPTH (32) words. Any word offered beyond that is dropped and `word_count` stays at DEPTH.
- R3: The start address is taken from `start_addr` on `addr_load` and is never incremented by the block. A second request without a new `addr_load` writes the same addresses again.
- R4: `req_bit` is 1 from the clock after `req_set` (when `word_count` is nonzero) until the copy has finished, and is then 0. No memory write happens before the sample strobe.
- R5: The copy starts on the clock edge that samples the first `sample_strobe` after the request. Writes are then issued on consecutive cycles to addresses start, start+1, …, start+count-1, and word i comes from buffer slot i.
- R6: Each copied word adds the sum of its four bytes, modulo 256, to `checksum`. A `cs_clr` pulse while idle sets `checksum` to 0.
- R7: `irq_flag` is set on the same edge at which `req_bit` falls. It stays set until an `irq_clr` pulse.
- R8: A word is built from WORD_W/BEAT_W beats, with the first beat placed in bits [BEAT_W-1:0]. A `beat_abort` pulse throws away a partly built word, and `word_count` does not change.
- R9: A request made while `word_count` is 0 makes no memory write. It leaves `req_bit` at 0 and sets `irq_flag` on the next edge.
- R10: While `req_bit` is 1, the block ignores `beat_vld`, `cnt_clr`, `addr_load`, `cs_clr` and `req_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_clr | input | 1 | Clear word counter and partial word |
| addr_load | input | 1 | Latch `start_addr` |
| start_addr | input | ADDR_W | Target start address |
| beat_vld | input | 1 | Beat present on `beat_data` |
| beat_data | input | BEAT_W | Load beat, lowest part of word first |
| beat_abort | input | 1 | Discard partly received word |
| req_set | input | 1 | Request batch commit |
| sample_strobe | input | 1 | Sample boundary marker |
| cs_clr | input | 1 | Clear checksum |
| irq_clr | input | 1 | Clear completion flag |
| req_bit | output | 1 | Request pending or copy running |
| word_count | output | $clog2(DEPTH)+1 | Words held in buffer |
| irq_flag | output | 1 | Commit complete flag |
| checksum | output | 8 | Byte-sum checksum |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 32 | Memory write data |

## Verification
- `word_count` moves on the edge that takes the last beat of a word.
- `req_bit` rises one edge after `req_set`. For a zero count, `irq_flag` instead rises one edge after `req_set`.
- With the strobe sampled at edge E0, word i is written at edge E0+i+1. `req_bit` falls and `irq_flag`, `checksum` settle at edge E0+count.
- The bench drives inputs and samples outputs on falling edges, counting those intervals exactly. It records every write at the rising edge and compares the list against a model kept from its own stimulus.

// File: rtl/rtcoef_pkg.sv
package rtcoef_pkg;
   localparam int RC_WORD_W = 32;

   typedef enum logic [1:0] {
      CP_IDLE = 2'd0,
      CP_WAIT = 2'd1,
      CP_COPY = 2'd2
   } cp_state_t;

   function automatic logic [7:0] word_byte_sum(input logic [RC_WORD_W-1:0] w);
      logic [7:0] s;
      s = 8'd0;
      for (int b = 0; b < RC_WORD_W / 8; b++) begin
         s = s + w[b*8 +: 8];
      end
      return s;
   endfunction
endpackage

// File: rtl/rtcoef_beat_pack.sv
module rtcoef_beat_pack #(
   parameter int WORD_W = 32,
   parameter int BEAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              beat_vld,
   input  logic [BEAT_W-1:0] beat_data,
   output logic              word_vld,
   output logic [WORD_W-1:0] word_data
);
   localparam int BEATS = WORD_W / BEAT_W;
   localparam int IW    = (BEATS > 1) ? $clog2(BEATS) : 1;

   generate
      if (BEATS == 1) begin : g_direct
         assign word_vld  = beat_vld & ~flush;
         assign word_data = beat_data;
      end else begin : g_pack
         logic [IW-1:0]     idx_q;
         logic [BEAT_W-1:0] lane_q [BEATS-1];
         logic              last;

         assign last = (idx_q == IW'(BEATS - 1));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               idx_q <= '0;
            end else if (flush) begin
               idx_q <= '0;
            end else if (beat_vld) begin
               idx_q <= last ? '0 : idx_q + IW'(1);
            end
         end

         always_ff @(posedge clk) begin
            if (beat_vld && !flush && !last) begin
               lane_q[idx_q] <= beat_data;
            end
         end

         always_comb begin
            for (int j = 0; j < BEATS - 1; j++) begin
               word_data[j*BEAT_W +: BEAT_W] = lane_q[j];
            end
            word_data[WORD_W-1 -: BEAT_W] = beat_data;
         end

         assign word_vld = beat_vld & ~flush & last;
      end
   endgenerate
endmodule

// File: rtl/rtcoef_stage_buf.sv
module rtcoef_stage_buf #(
   parameter int DEPTH  = 32,
   parameter int WORD_W = 32,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = PW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_clr,
   input  logic              wr_vld,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [PW-1:0]     rd_idx,
   output logic [CW-1:0]     count,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] slot_q [DEPTH];
   logic              room;

   assign room = (count < CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (cnt_clr) begin
         count <= '0;
      end else if (wr_vld && room) begin
         count <= count + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_vld && room && !cnt_clr) begin
         slot_q[count[PW-1:0]] <= wr_data;
      end
   end

   assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/rtcoef_commit_fsm.sv
module rtcoef_commit_fsm
   import rtcoef_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int ADDR_W = 12,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = PW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_set,
   input  logic                 strobe,
   input  logic                 cs_clr,
   input  logic                 irq_clr,
   input  logic [CW-1:0]        count,
   input  logic [ADDR_W-1:0]    base_addr,
   input  logic [RC_WORD_W-1:0] rd_data,
   output logic [PW-1:0]        rd_idx,
   output logic                 busy,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [RC_WORD_W-1:0] mem_wdata,
   output logic [7:0]           checksum,
   output logic                 irq_flag
);
   cp_state_t     state_q;
   logic [CW-1:0] idx_q;
   logic          last;
   logic          done_now;

   assign last     = ((idx_q + CW'(1)) == count);
   assign done_now = ((state_q == CP_COPY) && last) ||
                     ((state_q == CP_IDLE) && req_set && (count == '0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CP_IDLE;
         idx_q   <= '0;
      end else begin
         case (state_q)
            CP_IDLE: if (req_set && count != '0) state_q <= CP_WAIT;
            CP_WAIT: if (strobe) begin
               state_q <= CP_COPY;
               idx_q   <= '0;
            end
            CP_COPY: begin
               idx_q <= idx_q + CW'(1);
               if (last) state_q <= CP_IDLE;
            end
            default: state_q <= CP_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         checksum <= 8'd0;
      end else if (state_q == CP_COPY) begin
         checksum <= checksum + word_byte_sum(rd_data);
      end else if (state_q == CP_IDLE && cs_clr) begin
         checksum <= 8'd0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_flag <= 1'b0;
      end else if (done_now) begin
         irq_flag <= 1'b1;
      end else if (irq_clr) begin
         irq_flag <= 1'b0;
      end
   end

   assign busy      = (state_q != CP_IDLE);
   assign mem_we    = (state_q == CP_COPY);
   assign rd_idx    = idx_q[PW-1:0];
   assign mem_addr  = base_addr + ADDR_W'(idx_q);
   assign mem_wdata = rd_data;
endmodule

// File: rtl/rtcoef_stager.sv
module rtcoef_stager
   import rtcoef_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int ADDR_W = 12,
   parameter int BEAT_W = 8,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = PW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cnt_clr,
   input  logic                 addr_load,
   input  logic [ADDR_W-1:0]    start_addr,
   input  logic                 beat_vld,
   input  logic [BEAT_W-1:0]    beat_data,
   input  logic                 beat_abort,
   input  logic                 req_set,
   input  logic                 sample_strobe,
   input  logic                 cs_clr,
   input  logic                 irq_clr,
   output logic                 req_bit,
   output logic [CW-1:0]        word_count,
   output logic                 irq_flag,
   output logic [7:0]           checksum,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [RC_WORD_W-1:0] mem_wdata
);
   generate
      if (RC_WORD_W % BEAT_W != 0) begin : g_bad_beat
         $error("BEAT_W must divide the word width");
      end
      if ((1 << PW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (ADDR_W < CW) begin : g_bad_addr
         $error("ADDR_W too narrow for DEPTH");
      end
   endgenerate

   logic                 ld_ok;
   logic                 pk_vld;
   logic [RC_WORD_W-1:0] pk_data;
   logic [ADDR_W-1:0]    base_q;
   logic [PW-1:0]        rd_idx;
   logic [RC_WORD_W-1:0] rd_data;

   assign ld_ok = ~req_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (addr_load && ld_ok) begin
         base_q <= start_addr;
      end
   end

   rtcoef_beat_pack #(.WORD_W(RC_WORD_W), .BEAT_W(BEAT_W)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    ((beat_abort | cnt_clr) & ld_ok),
      .beat_vld (beat_vld & ld_ok),
      .beat_data(beat_data),
      .word_vld (pk_vld),
      .word_data(pk_data)
   );

   rtcoef_stage_buf #(.DEPTH(DEPTH), .WORD_W(RC_WORD_W)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_clr(cnt_clr & ld_ok),
      .wr_vld (pk_vld),
      .wr_data(pk_data),
      .rd_idx (rd_idx),
      .count  (word_count),
      .rd_data(rd_data)
   );

   rtcoef_commit_fsm #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_set  (req_set),
      .strobe   (sample_strobe),
      .cs_clr   (cs_clr),
      .irq_clr  (irq_clr),
      .count    (word_count),
      .base_addr(base_q),
      .rd_data  (rd_data),
      .rd_idx   (rd_idx),
      .busy     (req_bit),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .checksum (checksum),
      .irq_flag (irq_flag)
   );
endmodule

// File: rtl/rtcoef_stager_chk.sv
module rtcoef_stager_chk #(
   parameter int DEPTH  = 32,
   parameter int ADDR_W = 12,
   localparam int CW    = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sample_strobe,
   input logic              req_bit,
   input logic [CW-1:0]     word_count,
   input logic              irq_flag,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      word_count <= CW'(DEPTH)); // R2
   AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> req_bit); // R4
   AST_START_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $past(sample_strobe)); // R5
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R5
   AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_bit) |-> irq_flag); // R7
   AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      req_bit |=> $stable(word_count)); // R10
endmodule

bind rtcoef_stager rtcoef_stager_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sample_strobe(sample_strobe),
   .req_bit      (req_bit),
   .word_count   (word_count),
   .irq_flag     (irq_flag),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr)
);

// File: tb/rtcoef_stager_tb.sv
module rtcoef_stager_tb;
   localparam int DEPTH  = 32;
   localparam int ADDR_W = 12;
   localparam int BEAT_W = 8;
   localparam int BEATS  = 32 / BEAT_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cnt_clr = 0, addr_load = 0, beat_vld = 0, beat_abort = 0;
   logic req_set = 0, sample_strobe = 0, cs_clr = 0, irq_clr = 0;
   logic [ADDR_W-1:0] start_addr = '0;
   logic [BEAT_W-1:0] beat_data = '0;
   logic req_bit, irq_flag, mem_we;
   logic [5:0] word_count;
   logic [7:0] checksum;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0] mem_wdata;

   int checks = 0, errors = 0;
   logic [31:0] exp_buf [DEPTH];
   int exp_cnt = 0;
   logic [ADDR_W-1:0] exp_addr = '0;
   logic [7:0] exp_cs = 8'd0;
   bit exp_busy = 0;
   logic [ADDR_W-1:0] wa [64];
   logic [31:0] wd [64];
   int wr_n = 0;

   always #4 clk = ~clk;

   rtcoef_stager #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .addr_load(addr_load),
      .start_addr(start_addr), .beat_vld(beat_vld), .beat_data(beat_data),
      .beat_abort(beat_abort), .req_set(req_set), .sample_strobe(sample_strobe),
      .cs_clr(cs_clr), .irq_clr(irq_clr), .req_bit(req_bit),
      .word_count(word_count), .irq_flag(irq_flag), .checksum(checksum),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

   always @(posedge clk) begin
      if (rst_n && mem_we) begin
         if (wr_n < 64) begin
            wa[wr_n] = mem_addr;
            wd[wr_n] = mem_wdata;
         end
         wr_n = wr_n + 1;
      end
   end

   function automatic logic [7:0] bsum(input logic [31:0] w);
      return w[7:0] + w[15:8] + w[23:16] + w[31:24];
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic send_word(input logic [31:0] w);
      for (int b = 0; b < BEATS; b++) begin
         beat_vld = 1; beat_data = w[b*BEAT_W +: BEAT_W];
         tick();
      end
      beat_vld = 0;
      if (!exp_busy && exp_cnt < DEPTH) begin
         exp_buf[exp_cnt] = w;
         exp_cnt++;
      end
   endtask

   task automatic clear_cnt();
      cnt_clr = 1; tick(); cnt_clr = 0;
      if (!exp_busy) exp_cnt = 0;
   endtask

   task automatic load_addr(input logic [ADDR_W-1:0] a);
      start_addr = a; addr_load = 1; tick(); addr_load = 0;
      if (!exp_busy) exp_addr = a;
   endtask

   task automatic clear_cs();
      cs_clr = 1; tick(); cs_clr = 0;
      if (!exp_busy) exp_cs = 8'd0;
   endtask

   task automatic issue_req();
      wr_n = 0;
      req_set = 1; tick(); req_set = 0;
      if (exp_cnt == 0) begin
         chk(req_bit == 0, "R9 req_bit stays low", req_bit, 0);
         chk(irq_flag == 1, "R9 irq next edge", irq_flag, 1);
      end else begin
         exp_busy = 1;
         chk(req_bit == 1, "R4 req_bit set", req_bit, 1);
      end
   endtask

   task automatic finish_commit();
      int n = exp_cnt;
      bit ok = 1;
      logic [7:0] cs = exp_cs;
      chk(wr_n == 0, "R4 no write before strobe", wr_n, 0);
      sample_strobe = 1; tick(); sample_strobe = 0;
      repeat (n - 1) tick();
      chk(req_bit == 1, "R4 req_bit held during copy", req_bit, 1);
      tick();
      chk(req_bit == 0, "R4 req_bit cleared at end", req_bit, 0);
      chk(irq_flag == 1, "R7 irq on completion", irq_flag, 1);
      chk(wr_n == n, "R5 write count", wr_n, n);
      for (int i = 0; i < n && i < 64; i++) begin
         cs = cs + bsum(exp_buf[i]);
         if (wa[i] != ADDR_W'(exp_addr + i) || wd[i] != exp_buf[i]) begin
            ok = 0;
            $display("FAIL R5 word %0d actual=0x%0h@0x%0h expected=0x%0h@0x%0h",
                     i, wd[i], wa[i], exp_buf[i], ADDR_W'(exp_addr + i));
         end
      end
      chk(ok, "R5 write sequence", ok, 1);
      exp_cs = cs;
      chk(checksum == exp_cs, "R6 checksum", checksum, exp_cs);
      exp_busy = 0;
      tick();
      chk(irq_flag == 1, "R7 irq holds", irq_flag, 1);
      irq_clr = 1; tick(); irq_clr = 0;
      chk(irq_flag == 0, "R7 irq cleared", irq_flag, 0);
   endtask

   task automatic commit();
      issue_req();
      tick(); tick();
      finish_commit();
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL R4 watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) tick();
      rst_n = 1;
      tick();
      chk(word_count == 0 && req_bit == 0 && irq_flag == 0 && checksum == 0 && mem_we == 0,
          "R1 reset state", {word_count, req_bit, irq_flag, checksum, mem_we}, 0);

      // R1 / R5 / R6 basic batch
      clear_cnt(); load_addr(12'h100);
      send_word(32'h1122_3344); send_word(32'hDEAD_BEEF); send_word(32'h0000_00FF);
      send_word(32'h8000_0001); send_word(32'hCAFE_F00D);
      chk(word_count == 5, "R1 count increments", word_count, 5);
      clear_cnt();
      chk(word_count == 0, "R1 count clear", word_count, 0);
      send_word(32'h1122_3344); send_word(32'hDEAD_BEEF); send_word(32'h0000_00FF);
      commit();

      // R3 repeat request with no new address
      commit();

      // R6 checksum clear
      clear_cs();
      chk(checksum == 0, "R6 checksum clear", checksum, 0);

      // R8 partial word abort
      clear_cnt(); load_addr(12'h200);
      beat_vld = 1; beat_data = 8'hAA; tick(); beat_data = 8'hBB; tick(); beat_vld = 0;
      beat_abort = 1; tick(); beat_abort = 0;
      chk(word_count == 0, "R8 aborted word not counted", word_count, 0);
      send_word(32'h4433_2211);
      chk(word_count == 1, "R8 full word after abort", word_count, 1);
      commit();

      // R2 overflow
      clear_cnt(); load_addr(12'h300);
      for (int i = 0; i < DEPTH + 2; i++) send_word(32'h0101_0000 + i);
      chk(word_count == DEPTH, "R2 count saturates", word_count, DEPTH);
      commit();

      // R9 zero-count request
      clear_cnt();
      issue_req();
      tick(); tick();
      chk(wr_n == 0, "R9 no writes", wr_n, 0);
      irq_clr = 1; tick(); irq_clr = 0;

      // R10 loading side ignored while busy
      clear_cnt(); load_addr(12'h040);
      send_word(32'h1357_9BDF); send_word(32'h2468_ACE0);
      issue_req();
      send_word(32'hFFFF_FFFF);
      cnt_clr = 1; tick(); cnt_clr = 0;
      start_addr = 12'h777; addr_load = 1; tick(); addr_load = 0;
      cs_clr = 1; tick(); cs_clr = 0;
      chk(word_count == 2, "R10 count frozen while busy", word_count, 2);
      finish_commit();

      // random batches
      for (int t = 0; t < 12; t++) begin
         int n = 1 + ($urandom % DEPTH);
         clear_cnt();
         load_addr(ADDR_W'($urandom));
         if (($urandom % 3) == 0) clear_cs();
         for (int i = 0; i < n; i++) send_word($urandom);
         chk(word_count == n, "R1 random count", word_count, n);
         commit();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule